// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block takes one warp-wide access to an on-chip scratchpad and splits it into conflict-free passes. The scratchpad is split into 32 banks of one 4-byte word each. Each of the 32 lanes brings a word address and an active bit. A bank can serve only one word per cycle. Lanes whose addresses fall in the same bank but name different words must therefore be spread over separate cycles. Lanes that name the very same word share a slot, and that word is broadcast to all of them.

A request is taken in through a valid/ready handshake. From the next cycle the block issues one pass per cycle. Each pass gives a lane mask, plus a per-bank enable and word address that drive the bank arrays. When the final pass is out, a one-cycle done pulse appears together with the number of passes the request used. That count equals the worst pile-up of distinct words on a single bank. A column read of an unpadded 32-word-wide tile takes 32 passes. The same read on a tile whose rows are padded to 33 words takes one pass. The padding itself is left to the producer of the addresses.

Top module: `bank_conflict_serializer`

## Requirements
- R1: The bank of a lane is its word address modulo 32, which is the low 5 address bits. During a pass, `pass_bank_en[b]` is 1 exactly when the pass serves a lane in bank b. `pass_bank_addr[b*ADDR_W +: ADDR_W]` then holds that lane's word address.
- R2: Two active lanes in one bank with different word addresses are never served in the same pass.
- R3: Active lanes with an identical word address are served together, in the same pass.
- R4: In every pass, each bank that still has pending lanes takes the address of its lowest-numbered pending lane.
- R5: Passes come on consecutive cycles, starting in the cycle after a request with at least one active lane is accepted. Every pass serves at least one lane, and inactive lanes are never served.
- R6: In the cycle after the last pass, `done` is high for exactly one cycle. In that cycle, `pass_count` equals the largest number of distinct word addresses among active lanes of any one bank.
- R7: A request with no active lanes issues no pass. It raises `done` in the next cycle with `pass_count` = 0.
- R8: `req_ready` is low from the cycle after acceptance until the cycle after the last pass. Any `req_valid` presented while `req_ready` is low is ignored.
- R9: A request in which lane k reads word k*32+c takes 32 passes. A request in which lane k reads word k*33+c takes one pass.
- R10: After reset, `req_ready` is high, and `pass_valid`, `done` and `pass_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Block is idle and takes a request |
| req_active | input | LANES | Active bit of each lane |
| req_addr | input | LANES*ADDR_W | Word address of each lane, lane k at bits k*ADDR_W |
| pass_valid | output | 1 | A pass is issued this cycle |
| pass_lanes | output | LANES | Lanes served by this pass |
| pass_bank_en | output | BANKS | Banks accessed by this pass |
| pass_bank_addr | output | BANKS*ADDR_W | Word address per bank, bank b at bits b*ADDR_W |
| done | output | 1 | One-cycle pulse after the last pass |
| pass_count | output | clog2(LANES+1) | Passes used by the finished request |

## Verification
Suppose the pending-lane state goes wrong, for example a lane is cleared without being served or kept after it was served. The lane mask is wrong in the very next pass. The done pulse then moves one or more cycles away from where the conflict depth predicts it. A broken bank index or leader choice shows up in the first pass as a wrong bank enable or bank address. A broken pass counter shows up only at the done pulse, as a count that does not match the worst bank depth. The cycle-by-cycle comparison catches all of these in the cycle they first appear.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } seq_state_e;

    localparam int unsigned SCAN_MAX = 64;

    // Index of the lowest set bit; 0 when the vector is empty.
    function automatic int unsigned lowest_set(input logic [SCAN_MAX-1:0] v);
        int unsigned idx = 0;
        for (int i = SCAN_MAX - 1; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/bcs_bank_decode.sv
module bcs_bank_decode #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic [LANES-1:0]                  pending,
    input  logic [LANES*BANK_W-1:0]           lane_bank,
    output logic [BANKS-1:0][LANES-1:0]       bank_hit
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign bank_hit[b][l] = pending[l] &&
                (lane_bank[l*BANK_W +: BANK_W] == BANK_W'(b));
        end
    end

endmodule

// File: rtl/bcs_bank_leader.sv
module bcs_bank_leader
    import bcs_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 12,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]        hit,
    input  logic [LANES*ADDR_W-1:0] addr,
    output logic                    valid,
    output logic [ADDR_W-1:0]       lead_addr
);

    logic [LANE_W-1:0] lead_idx;
    logic [ADDR_W-1:0] addr_arr [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_unpack
        assign addr_arr[l] = addr[l*ADDR_W +: ADDR_W];
    end

    always_comb begin
        lead_idx  = LANE_W'(lowest_set(SCAN_MAX'(hit)));
        valid     = |hit;
        lead_addr = valid ? addr_arr[lead_idx] : '0;
    end

endmodule

// File: rtl/bcs_lane_match.sv
module bcs_lane_match #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic [LANES-1:0]        pending,
    input  logic [LANES*ADDR_W-1:0] addr,
    input  logic [LANES*BANK_W-1:0] lane_bank,
    input  logic [BANKS*ADDR_W-1:0] bank_addr,
    output logic [LANES-1:0]        sel
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BANK_W-1:0] bk;
        assign bk     = lane_bank[l*BANK_W +: BANK_W];
        assign sel[l] = pending[l] &&
            (addr[l*ADDR_W +: ADDR_W] == bank_addr[bk*ADDR_W +: ADDR_W]);
    end

endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
    import bcs_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [LANES-1:0]             req_active,
    input  logic [LANES*ADDR_W-1:0]      req_addr,
    output logic                         pass_valid,
    output logic [LANES-1:0]             pass_lanes,
    output logic [BANKS-1:0]             pass_bank_en,
    output logic [BANKS*ADDR_W-1:0]      pass_bank_addr,
    output logic                         done,
    output logic [$clog2(LANES+1)-1:0]   pass_count
);

    localparam int BANK_W = $clog2(BANKS);
    localparam int CNT_W  = $clog2(LANES + 1);

    seq_state_e                state_q;
    logic [LANES-1:0]          pending_q;
    logic [LANES*ADDR_W-1:0]   addr_q;
    logic [CNT_W-1:0]          cnt_q;
    logic [CNT_W-1:0]          count_q;
    logic                      done_q;

    logic [LANES*BANK_W-1:0]   lane_bank;
    logic [BANKS-1:0][LANES-1:0] bank_hit;
    logic [BANKS-1:0]          bank_valid;
    logic [BANKS*ADDR_W-1:0]   bank_addr;
    logic [LANES-1:0]          sel;
    logic [LANES-1:0]          remain;
    logic                      accept;

    for (genvar l = 0; l < LANES; l++) begin : g_bank_idx
        assign lane_bank[l*BANK_W +: BANK_W] = addr_q[l*ADDR_W +: BANK_W];
    end

    bcs_bank_decode #(.LANES(LANES), .BANKS(BANKS)) u_decode (
        .pending   (pending_q),
        .lane_bank (lane_bank),
        .bank_hit  (bank_hit)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_leader
        bcs_bank_leader #(.LANES(LANES), .ADDR_W(ADDR_W)) u_leader (
            .hit       (bank_hit[b]),
            .addr      (addr_q),
            .valid     (bank_valid[b]),
            .lead_addr (bank_addr[b*ADDR_W +: ADDR_W])
        );
    end

    bcs_lane_match #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_match (
        .pending   (pending_q),
        .addr      (addr_q),
        .lane_bank (lane_bank),
        .bank_addr (bank_addr),
        .sel       (sel)
    );

    assign accept = req_valid && req_ready;
    assign remain = pending_q & ~sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pending_q <= '0;
            addr_q    <= '0;
            cnt_q     <= '0;
            count_q   <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q    <= req_addr;
                        pending_q <= req_active;
                        cnt_q     <= '0;
                        if (req_active == '0) begin
                            done_q  <= 1'b1;
                            count_q <= '0;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    pending_q <= remain;
                    cnt_q     <= cnt_q + 1'b1;
                    if (remain == '0) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        count_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready      = (state_q == ST_IDLE);
    assign pass_valid     = (state_q == ST_ISSUE);
    assign pass_lanes     = pass_valid ? sel : '0;
    assign pass_bank_en   = pass_valid ? bank_valid : '0;
    assign pass_bank_addr = pass_valid ? bank_addr : '0;
    assign done           = done_q;
    assign pass_count     = count_q;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int LANES = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [LANES-1:0]           req_active,
    input logic                       pass_valid,
    input logic [LANES-1:0]           pass_lanes,
    input logic                       done,
    input logic [$clog2(LANES+1)-1:0] pass_count
);

    // R8: no request can be taken while a pass is out
    p_pass_blocks_ready_r8: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> !req_ready);

    // R5: first pass follows acceptance of a non-empty request
    p_first_pass_next_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_active != '0)) |=> pass_valid);

    // R5: every pass serves some lane
    p_pass_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> (pass_lanes != '0));

    // R7: empty request completes at once with zero passes
    p_empty_done_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_active == '0)) |=>
            (done && (pass_count == '0) && !pass_valid));

    // R6: done never overlaps a pass and the count stays in range
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!pass_valid && (int'(pass_count) <= LANES)));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind bank_conflict_serializer bcs_checker #(.LANES(LANES)) u_bcs_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_active (req_active),
    .pass_valid (pass_valid),
    .pass_lanes (pass_lanes),
    .done       (done),
    .pass_count (pass_count)
);

// File: tb/bank_conflict_serializer_test.sv
module bank_conflict_serializer_test;

    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 32;
    localparam int BANKS  = 32;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = $clog2(LANES + 1);
    localparam int WATCHDOG = 150000;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      req_valid = 1'b0;
    logic                      req_ready;
    logic [LANES-1:0]          req_active = '0;
    logic [LANES*ADDR_W-1:0]   req_addr = '0;
    logic                      pass_valid;
    logic [LANES-1:0]          pass_lanes;
    logic [BANKS-1:0]          pass_bank_en;
    logic [BANKS*ADDR_W-1:0]   pass_bank_addr;
    logic                      done;
    logic [CNT_W-1:0]          pass_count;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int m_addr [LANES];
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_conflict_serializer #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr), .pass_valid(pass_valid),
        .pass_lanes(pass_lanes), .pass_bank_en(pass_bank_en),
        .pass_bank_addr(pass_bank_addr), .done(done), .pass_count(pass_count)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d exp=%0d cycles", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 8);
    endfunction

    function automatic int depth_of(input logic [LANES-1:0] act);
        int worst = 0;
        for (int b = 0; b < BANKS; b++) begin
            int distinct = 0;
            for (int l = 0; l < LANES; l++) begin
                if (act[l] && (m_addr[l] % BANKS) == b) begin
                    bit seen = 0;
                    for (int k = 0; k < l; k++)
                        if (act[k] && m_addr[k] == m_addr[l]) seen = 1;
                    if (!seen) distinct++;
                end
            end
            if (distinct > worst) worst = distinct;
        end
        return worst;
    endfunction

    task automatic run_req(input logic [LANES-1:0] act, input bit junk, input string tag);
        logic [LANES-1:0] pend = act;
        int exp_cnt = depth_of(act);
        int passes = 0;
        int guard = 0;
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        req_active = act;
        for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(m_addr[l]);
        req_valid = 1'b1;
        @(negedge clk);
        if (junk && pend != '0) begin
            req_active = ~act;
            req_addr   = ~req_addr;
        end else begin
            req_valid = 1'b0;
        end
        while (pend != '0 && passes <= LANES) begin
            logic [LANES-1:0] e_sel = '0;
            logic [BANKS-1:0] e_en  = '0;
            int e_addr [BANKS];
            for (int b = 0; b < BANKS; b++) begin
                int lead = -1;
                e_addr[b] = 0;
                for (int l = 0; l < LANES; l++)
                    if (pend[l] && (m_addr[l] % BANKS) == b && lead < 0) lead = l;
                if (lead >= 0) begin
                    e_en[b] = 1'b1;
                    e_addr[b] = m_addr[lead];
                    for (int l = 0; l < LANES; l++)
                        if (pend[l] && m_addr[l] == m_addr[lead]) e_sel[l] = 1'b1;
                end
            end
            check("R5", {tag, " pass_valid"}, pass_valid, 1);
            check("R8", {tag, " req_ready during pass"}, req_ready, 0);
            check("R2/R3/R4", {tag, " pass_lanes"}, pass_lanes, e_sel);
            check("R1", {tag, " pass_bank_en"}, pass_bank_en, e_en);
            for (int b = 0; b < BANKS; b++)
                if (e_en[b])
                    check("R1", {tag, " bank addr"},
                          pass_bank_addr[b*ADDR_W +: ADDR_W], e_addr[b]);
            check("R6", {tag, " done during pass"}, done, 0);
            pend &= ~e_sel;
            passes++;
            if (pend == '0) req_valid = 1'b0;
            @(negedge clk);
        end
        check("R5", {tag, " no pass after last"}, pass_valid, 0);
        check("R6", {tag, " done"}, done, 1);
        check("R6", {tag, " pass_count"}, pass_count, exp_cnt);
        check("R6", {tag, " passes issued"}, passes, exp_cnt);
        check("R8", {tag, " ready after"}, req_ready, 1);
        @(negedge clk);
        check("R6", {tag, " done pulse width"}, done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10", "ready after reset", req_ready, 1);
        check("R10", "pass_valid after reset", pass_valid, 0);
        check("R10", "done after reset", done, 0);
        check("R10", "count after reset", pass_count, 0);

        for (int l = 0; l < LANES; l++) m_addr[l] = 64 + l;
        run_req('1, 0, "unit stride R1");

        for (int l = 0; l < LANES; l++) m_addr[l] = l * 32 + 5;
        run_req('1, 0, "column 32 wide R9");
        check("R9", "column 32 count", pass_count, 32);

        for (int l = 0; l < LANES; l++) m_addr[l] = l * 33 + 5;
        run_req('1, 0, "column padded R9");
        check("R9", "padded count", pass_count, 1);

        for (int l = 0; l < LANES; l++) m_addr[l] = 77;
        run_req('1, 0, "broadcast R3");

        for (int l = 0; l < LANES; l++) m_addr[l] = 2 * l;
        run_req('1, 0, "stride two R2");

        run_req('0, 0, "empty R7");
        check("R7", "empty count", pass_count, 0);

        for (int l = 0; l < LANES; l++) m_addr[l] = l;
        m_addr[0] = 3; m_addr[31] = 35; m_addr[3] = 67;
        run_req(32'h8000_0009, 0, "lowest lane first R4");

        for (int l = 0; l < LANES; l++) m_addr[l] = l * 32 + 1;
        run_req(32'h0F0F_0F0F, 1, "held valid ignored R8");

        for (int t = 0; t < 40; t++) begin
            logic [LANES-1:0] act;
            for (int l = 0; l < LANES; l++)
                m_addr[l] = (next_rand() % 6) * 32 + (next_rand() % 4);
            act = LANES'(next_rand()) | LANES'(next_rand() << 16);
            run_req(act, t[0], "mixed R2 R3 R6");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule